// File: doc/BRIEF.md
# Flag Offset Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag comparators compare against, and it presents them continuously on two output buses. Software or a neighbouring controller programs the offsets from the write-clock side. Programming is either one bit per clock through a serial input or one word per clock from the data input bus. From the read-clock side, the same values can be read back word by word onto the data output bus. Readback works whichever programming method is in force.

The programming method is fixed by the load input while master reset is held. That choice also picks the default offsets: 127 for word-wide programming and 1,023 for bit-serial programming. Partial reset returns both word sequences to their first step but keeps the offsets and the chosen method, so a FIFO can be flushed mid-operation without reprogramming its flags. All enables, the load input and both resets are active-low. The offset width is log2 of the FIFO depth. With the default parameters this gives 15 bits, carried over a 9-bit data bus.

Top module: `ofl_offset_loader`

## Requirements
- R1: With `ld_n` low throughout master reset (and for two `wclk` edges after `mrs_n` rises), the block enters word-wide mode and both `ae_ofs` and `af_ofs` equal 127.
- R2: With `ld_n` high throughout master reset (and for two `wclk` edges after `mrs_n` rises), the block enters bit-serial mode and both `ae_ofs` and `af_ofs` equal 1,023.
- R3: In word-wide mode, each `wclk` edge with `wen_n` and `ld_n` both low writes `din` into the next of four steps. Step 0 is `ae_ofs[8:0]`. Step 1 is `ae_ofs[14:9]` from `din[5:0]`, with `din[8:6]` ignored. Step 2 is `af_ofs[8:0]`. Step 3 is `af_ofs[14:9]` from `din[5:0]`. After step 3 the sequence returns to step 0. The new value appears on the offset ports after that edge.
- R4: In bit-serial mode, each `wclk` edge with `sen_n` and `ld_n` both low stores `si` into the next bit. Bits 0 to 14 of `ae_ofs` are filled least significant first, then bits 0 to 14 of `af_ofs`. After 30 bits the next bit goes to `ae_ofs[0]` again.
- R5: Each `rclk` edge with `ren_n` and `ld_n` both low loads `q` with the next of the same four steps as R3. High parts are zero-extended in `q[5:0]`. This works in either mode. `q` holds otherwise and is 0 after any reset.
- R6: Partial reset (`prs_n` low) leaves `ae_ofs`, `af_ofs` and the mode unchanged. It returns the write step, the serial bit position and the read step to their first position.
- R7: The other method's enable has no effect. `sen_n` is ignored in word-wide mode and `wen_n` is ignored in bit-serial mode.
- R8: With `ld_n` high, `wen_n` and `sen_n` change no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrs_n | input | 1 | Master reset, active-low; selects mode and defaults |
| prs_n | input | 1 | Partial reset, active-low; resets sequences only |
| ld_n | input | 1 | Load qualifier, active-low; mode select during master reset |
| wen_n | input | 1 | Word-wide write enable, active-low |
| sen_n | input | 1 | Serial shift enable, active-low |
| si | input | 1 | Serial data bit |
| din | input | DATA_W | Data input bus |
| ren_n | input | 1 | Readback enable, active-low |
| q | output | DATA_W | Readback data bus |
| ae_ofs | output | OFS_W | Almost-empty offset to flag logic |
| af_ofs | output | OFS_W | Almost-full offset to flag logic |

## Verification
A write or serial shift that takes effect on a `wclk` edge shows on `ae_ofs`/`af_ofs` right after that edge. A readback on an `rclk` edge is on `q` right after its edge. Resets release two edges after the pin rises, through a two-stage synchronizer. The bench drives every input on the falling edge and samples on the following falling edge, half a cycle after the capturing edge. After a reset pin rises, it waits three full cycles so that both synchronizer stages have released before the next command.

// File: rtl/ofl_pkg.sv
package ofl_pkg;
  typedef enum logic {
    PGM_WORD = 1'b0,
    PGM_BIT  = 1'b1
  } pgm_mode_e;
endpackage

// File: rtl/ofl_rst_sync.sv
module ofl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/ofl_wr_port.sv
module ofl_wr_port
  import ofl_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFS_W    = 15,
  parameter int DFLT_WRD = 127,
  parameter int DFLT_BIT = 1023
) (
  input  logic              wclk,
  input  logic              mrst_n,
  input  logic              arst_n,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic              sen_n,
  input  logic              si,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  localparam int LO_W   = DATA_W;
  localparam int HI_W   = OFS_W - DATA_W;
  localparam int SBITS  = 2 * OFS_W;
  localparam int SCNT_W = $clog2(SBITS);
  localparam logic [OFS_W-1:0]  DEF_W    = OFS_W'(DFLT_WRD);
  localparam logic [OFS_W-1:0]  DEF_B    = OFS_W'(DFLT_BIT);
  localparam logic [SCNT_W-1:0] SCNT_TOP = SCNT_W'(SBITS - 1);

  pgm_mode_e          mode_q, mode_d;
  logic [OFS_W-1:0]   ae_q, ae_d, af_q, af_d;
  logic [OFS_W-1:0]   ae_ser, af_ser;
  logic [1:0]         widx_q, widx_d;
  logic [SCNT_W-1:0]  scnt_q, scnt_d;
  logic               word_we, bit_we, ofs_en;

  assign word_we = arst_n && (mode_q == PGM_WORD) && !wen_n && !ld_n;
  assign bit_we  = arst_n && (mode_q == PGM_BIT)  && !sen_n && !ld_n;
  assign ofs_en  = !mrst_n || word_we || bit_we;

  // one-bit update lanes for serial programming
  for (genvar i = 0; i < OFS_W; i++) begin : g_lane
    assign ae_ser[i] = (bit_we && scnt_q == SCNT_W'(i))         ? si : ae_q[i];
    assign af_ser[i] = (bit_we && scnt_q == SCNT_W'(i + OFS_W)) ? si : af_q[i];
  end

  always_comb begin
    mode_d = mode_q;
    ae_d   = ae_ser;
    af_d   = af_ser;
    if (!mrst_n) begin
      mode_d = ld_n ? PGM_BIT : PGM_WORD;
      ae_d   = ld_n ? DEF_B : DEF_W;
      af_d   = ld_n ? DEF_B : DEF_W;
    end else if (word_we) begin
      case (widx_q)
        2'd0:    ae_d[LO_W-1:0]     = din;
        2'd1:    ae_d[OFS_W-1:LO_W] = din[HI_W-1:0];
        2'd2:    af_d[LO_W-1:0]     = din;
        default: af_d[OFS_W-1:LO_W] = din[HI_W-1:0];
      endcase
    end
  end

  always_comb begin
    widx_d = word_we ? widx_q + 2'd1 : widx_q;
    scnt_d = scnt_q;
    if (bit_we) scnt_d = (scnt_q == SCNT_TOP) ? '0 : scnt_q + 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (ofs_en) begin
      mode_q <= mode_d;
      ae_q   <= ae_d;
      af_q   <= af_d;
    end
  end

  always_ff @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      widx_q <= '0;
      scnt_q <= '0;
    end else begin
      widx_q <= widx_d;
      scnt_q <= scnt_d;
    end
  end

  assign ae_ofs = ae_q;
  assign af_ofs = af_q;

  AST_MODE_FROZEN: assert property (@(posedge wclk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_q)); // R6
  AST_PRS_KEEPS_OFS: assert property (@(posedge wclk) disable iff (!mrst_n)
    !arst_n |=> ($stable(ae_q) && $stable(af_q))); // R6
  AST_BIT_MODE_NO_WSTEP: assert property (@(posedge wclk) disable iff (!arst_n)
    (mode_q == PGM_BIT) |=> $stable(widx_q)); // R7
  AST_WORD_MODE_NO_SSTEP: assert property (@(posedge wclk) disable iff (!arst_n)
    (mode_q == PGM_WORD) |=> $stable(scnt_q)); // R7
  AST_IDLE_NO_LOAD: assert property (@(posedge wclk) disable iff (!mrst_n)
    ld_n |=> ($stable(ae_q) && $stable(af_q))); // R8
endmodule

// File: rtl/ofl_rd_port.sv
module ofl_rd_port #(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 15
) (
  input  logic              rclk,
  input  logic              arst_n,
  input  logic              ren_n,
  input  logic              ld_n,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [DATA_W-1:0] q
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = OFS_W - DATA_W;
  localparam int PAD  = DATA_W - HI_W;

  logic [1:0]        ridx_q, ridx_d;
  logic [DATA_W-1:0] q_q, q_d, word;
  logic              rd_en;

  assign rd_en = !ren_n && !ld_n;

  always_comb begin
    case (ridx_q)
      2'd0:    word = ae_ofs[LO_W-1:0];
      2'd1:    word = {{PAD{1'b0}}, ae_ofs[OFS_W-1:LO_W]};
      2'd2:    word = af_ofs[LO_W-1:0];
      default: word = {{PAD{1'b0}}, af_ofs[OFS_W-1:LO_W]};
    endcase
    ridx_d = rd_en ? ridx_q + 2'd1 : ridx_q;
    q_d    = rd_en ? word : q_q;
  end

  always_ff @(posedge rclk or negedge arst_n) begin
    if (!arst_n) begin
      ridx_q <= '0;
      q_q    <= '0;
    end else begin
      ridx_q <= ridx_d;
      q_q    <= q_d;
    end
  end

  assign q = q_q;

  AST_Q_HOLD: assert property (@(posedge rclk) disable iff (!arst_n)
    !rd_en |=> $stable(q)); // R5
  AST_RIDX_WRAP: assert property (@(posedge rclk) disable iff (!arst_n)
    (rd_en && ridx_q == 2'd3) |=> (ridx_q == 2'd0)); // R5
endmodule

// File: rtl/ofl_offset_loader.sv
module ofl_offset_loader #(
  parameter int FIFO_DEPTH = 32768,
  parameter int DATA_W     = 9,
  parameter int DFLT_WRD   = 127,
  parameter int DFLT_BIT   = 1023,
  parameter int OFS_W      = $clog2(FIFO_DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrs_n,
  input  logic              prs_n,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic              sen_n,
  input  logic              si,
  input  logic [DATA_W-1:0] din,
  input  logic              ren_n,
  output logic [DATA_W-1:0] q,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  logic any_rst_n;
  logic w_mrst_n, w_arst_n, r_arst_n;

  assign any_rst_n = mrs_n & prs_n;

  ofl_rst_sync u_sync_wm (.clk(wclk), .arst_n(mrs_n),     .srst_n(w_mrst_n));
  ofl_rst_sync u_sync_wa (.clk(wclk), .arst_n(any_rst_n), .srst_n(w_arst_n));
  ofl_rst_sync u_sync_ra (.clk(rclk), .arst_n(any_rst_n), .srst_n(r_arst_n));

  ofl_wr_port #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .DFLT_WRD(DFLT_WRD), .DFLT_BIT(DFLT_BIT)
  ) u_wr (
    .wclk(wclk), .mrst_n(w_mrst_n), .arst_n(w_arst_n), .ld_n(ld_n),
    .wen_n(wen_n), .sen_n(sen_n), .si(si), .din(din),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  ofl_rd_port #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .rclk(rclk), .arst_n(r_arst_n), .ren_n(ren_n), .ld_n(ld_n),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .q(q)
  );
endmodule

// File: tb/tb_ofl_offset_loader.sv
module tb_ofl_offset_loader;
  localparam int DW = 9;
  localparam int OW = 15;

  logic clk = 1'b0;
  logic mrs_n, prs_n, ld_n, wen_n, sen_n, si, ren_n;
  logic [DW-1:0] din, q;
  logic [OW-1:0] ae_ofs, af_ofs;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  ofl_offset_loader dut (
    .wclk(clk), .rclk(clk), .mrs_n(mrs_n), .prs_n(prs_n), .ld_n(ld_n),
    .wen_n(wen_n), .sen_n(sen_n), .si(si), .din(din), .ren_n(ren_n),
    .q(q), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  // {din written, word expected on readback}
  localparam logic [17:0] PVEC [8] = '{
    {9'h05A, 9'h05A}, {9'h1C3, 9'h003}, {9'h0F0, 9'h0F0}, {9'h1FF, 9'h03F},
    {9'h000, 9'h000}, {9'h1C0, 9'h000}, {9'h1FF, 9'h1FF}, {9'h03F, 9'h03F}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic master_reset(logic sel);
    @(negedge clk);
    mrs_n = 0; ld_n = sel;
    repeat (3) @(negedge clk);
    mrs_n = 1;
    repeat (3) @(negedge clk);
    ld_n = 1;
  endtask

  task automatic partial_reset();
    @(negedge clk);
    prs_n = 0;
    repeat (2) @(negedge clk);
    prs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_word(logic [DW-1:0] w);
    @(negedge clk);
    wen_n = 0; ld_n = 0; din = w;
    @(negedge clk);
    wen_n = 1; ld_n = 1;
  endtask

  task automatic sh_bit(logic b);
    @(negedge clk);
    sen_n = 0; ld_n = 0; si = b;
    @(negedge clk);
    sen_n = 1; ld_n = 1;
  endtask

  task automatic rd_word(output logic [DW-1:0] w);
    @(negedge clk);
    ren_n = 0; ld_n = 0;
    @(negedge clk);
    ren_n = 1; ld_n = 1;
    w = q;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rw;
    logic [OW-1:0] ae_val, af_val;
    mrs_n = 0; prs_n = 1; ld_n = 0; wen_n = 1; sen_n = 1; si = 0; ren_n = 1; din = '0;

    // R1 reset state, word-wide mode
    master_reset(1'b0);
    chk("R1 ae default", ae_ofs, 127);
    chk("R1 af default", af_ofs, 127);
    chk("R5 q after reset", q, 0);
    rd_word(rw); chk("R5 read ae lo", rw, 9'h07F);
    rd_word(rw); chk("R5 read ae hi", rw, 9'h000);
    rd_word(rw); chk("R5 read af lo", rw, 9'h07F);
    rd_word(rw); chk("R5 read af hi", rw, 9'h000);
    chk("R5 q holds", q, 9'h000);

    // R8 ld_n high: no load
    @(negedge clk); wen_n = 0; sen_n = 0; si = 1; din = 9'h155; ld_n = 1;
    @(negedge clk); wen_n = 1; sen_n = 1;
    chk("R8 ae unchanged", ae_ofs, 127);
    chk("R8 af unchanged", af_ofs, 127);

    // R7 serial enable ignored in word mode
    for (int i = 0; i < 3; i++) sh_bit(1'b0);
    chk("R7 ae no serial in word mode", ae_ofs, 127);

    // R3 table-driven word writes and R5 readback
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 4; k++) wr_word(PVEC[g*4+k][17:9]);
      ae_val = {PVEC[g*4+1][5:0], PVEC[g*4+0][8:0]};
      af_val = {PVEC[g*4+3][5:0], PVEC[g*4+2][8:0]};
      chk("R3 ae after 4 words", ae_ofs, ae_val);
      chk("R3 af after 4 words", af_ofs, af_val);
      for (int k = 0; k < 4; k++) begin
        rd_word(rw);
        chk("R5 readback step", rw, PVEC[g*4+k][8:0]);
      end
    end

    // R6 partial reset keeps offsets, resets steps
    wr_word(9'h011);
    rd_word(rw);
    partial_reset();
    chk("R6 ae kept", ae_ofs, 15'h0011);
    chk("R6 af kept", af_ofs, 15'h7FFF);
    chk("R6 q cleared", q, 0);
    wr_word(9'h022);
    chk("R6 write step restarts", ae_ofs, 15'h0022);
    rd_word(rw); chk("R6 read step restarts", rw, 9'h022);
    sh_bit(1'b1);
    chk("R6 mode kept (serial ignored)", ae_ofs, 15'h0022);

    // R2 serial mode defaults
    master_reset(1'b1);
    chk("R2 ae default", ae_ofs, 1023);
    chk("R2 af default", af_ofs, 1023);
    rd_word(rw); chk("R5 serial-mode read ae lo", rw, 9'h1FF);
    rd_word(rw); chk("R5 serial-mode read ae hi", rw, 9'h001);

    // R4 serial shifting order
    for (int i = 0; i < OW; i++) sh_bit(ae_val_bit(15'h1234, i));
    chk("R4 ae filled first", ae_ofs, 15'h1234);
    chk("R4 af untouched yet", af_ofs, 1023);
    for (int i = 0; i < OW; i++) sh_bit(ae_val_bit(15'h4321, i));
    chk("R4 af filled second", af_ofs, 15'h4321);
    sh_bit(1'b1);
    chk("R4 wrap to ae bit0", ae_ofs, 15'h1235);

    // R7 word write ignored in serial mode
    wr_word(9'h0AA);
    chk("R7 ae no word write in serial mode", ae_ofs, 15'h1235);
    chk("R7 af no word write in serial mode", af_ofs, 15'h4321);

    // R1 back to word mode
    master_reset(1'b0);
    chk("R1 defaults restored", ae_ofs, 127);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic logic ae_val_bit(logic [OW-1:0] v, int i);
    return v[i];
  endfunction
endmodule